// File: doc/BRIEF.md
# Receive Frame Aggregator for a Bulk-In Stream

This block takes complete received Ethernet frames, each already carrying its 4-byte frame check sequence, and repacks them into a byte stream for a bulk-in endpoint. Every frame becomes a record. The record starts with three header bytes: the receive status byte, then the record length as a 16-bit value sent low byte first. The frame bytes follow, FCS included. Records are placed back to back inside one transfer until the next record would no longer fit in the transfer buffer. The transfer is also closed when no new frame arrives within a programmable idle window.

The block stores one whole frame before it forwards anything, because the header must carry the length. While a stored frame is being read out, the input is held off. The final byte of each record is held back in a single register until the block knows whether that byte ends the transfer. It then leaves with or without the transfer-end marker. As a result, a record is never split between two transfers. A frame longer than the allowed maximum is discarded whole and counted.

Top module: `rxagg_top`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and drop_count is 0.
- R2: Each record leaves as byte 0 = status, byte 1 = length bits 7:0, byte 2 = length bits 15:8, then every frame byte in arrival order.
- R3: The length field equals the number of input bytes of the frame, the 4 FCS bytes included.
- R4: The status byte of a record is the in_status value presented with the frame's last input byte (0x40 marks a good frame) and passes through unchanged.
- R5: When a new frame is ready while the previous record's final byte is held, and the new record fits in the remaining transfer space of XFER_BYTES (3072) bytes, the held byte leaves with out_last=0 and the new record follows in the same transfer.
- R6: When the new record would exceed XFER_BYTES, the held byte leaves with out_last=1 and the new record opens a new transfer; no transfer ever exceeds XFER_BYTES.
- R7: When a final byte is held and no frame becomes ready for idle_limit cycles after the hold begins, the held byte leaves with out_last=1.
- R8: A frame of more than MAX_PAYLOAD+4 (1518) input bytes produces no output and increments drop_count by one; a frame of exactly 1518 bytes is forwarded.
- R9: If the idle window expires in the same cycle that a new frame becomes ready, the expiry wins: the held byte ends the transfer and the new frame starts the next one.
- R10: While a stored frame waits for or undergoes read-out, in_ready stays 0.
- R11: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte accepted this cycle when in_valid is 1 |
| in_data | input | 8 | Frame byte, FCS included |
| in_last | input | 1 | Marks the last byte of a frame |
| in_status | input | 8 | Receive status, taken with the last byte |
| idle_limit | input | TMO_W | Idle window in cycles before a held record is closed |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output record byte |
| out_last | output | 1 | Last byte of a transfer |
| drop_count | output | DROP_W | Number of oversized frames discarded |

## Verification
Two events can fall in one cycle: the idle window expiring and the next frame becoming ready while a final byte is held. The bench provokes this by setting idle_limit to L and sending a frame of exactly L bytes right behind the previous one, so that its completion lands on the expiry cycle. It then checks that the held byte carries the transfer-end marker. Frames of L-1 and L+1 bytes are sent under the same conditions and must join the transfer or close it, respectively. The expected out_last of every held byte comes from the bench's own model of transfer fill and elapsed idle time.

// File: rtl/rxagg_pkg.sv
// Shared types for the receive frame aggregator.
package rxagg_pkg;

    // Emitter sequencing: wait, release held byte (join or close), header, body.
    typedef enum logic [2:0] {
        ST_WAIT,
        ST_JOIN,
        ST_FLUSH,
        ST_HDR_STAT,
        ST_HDR_LO,
        ST_HDR_HI,
        ST_BODY
    } emit_state_t;

    localparam int unsigned HDR_BYTES = 3;

endpackage

// File: rtl/rxagg_capture.sv
// Store-and-forward frame buffer.
// Accepts one frame byte per cycle until a whole frame is held, then blocks
// input until the reader releases it. Frames longer than MAX_LEN bytes are
// discarded at their last byte and counted. Assumes in_last marks each frame end.
module rxagg_capture #(
    parameter int unsigned MAX_LEN = 1518,
    parameter int unsigned LEN_W   = 11,
    parameter int unsigned DROP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic [7:0]        in_status,
    output logic              frm_ready,
    output logic [LEN_W-1:0]  frm_len,
    output logic [7:0]        frm_status,
    input  logic              frm_release,
    input  logic [LEN_W-1:0]  rd_addr,
    output logic [7:0]        rd_data,
    output logic [DROP_W-1:0] drop_count
);
    logic [7:0]       mem [MAX_LEN];
    logic [LEN_W-1:0] wcnt;
    logic             full;
    logic             beat;

    assign in_ready  = !full;
    assign beat      = in_valid && !full;
    assign frm_ready = full;
    assign rd_data   = mem[rd_addr];

    // Frame storage write; bytes beyond MAX_LEN are not stored.
    always_ff @(posedge clk) begin
        if (beat && (wcnt < LEN_W'(MAX_LEN))) begin
            mem[wcnt] <= in_data;
        end
    end

    // Byte count, frame completion, drop decision and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt       <= '0;
            full       <= 1'b0;
            frm_len    <= '0;
            frm_status <= '0;
            drop_count <= '0;
        end else if (frm_release) begin
            full <= 1'b0;
            wcnt <= '0;
        end else if (beat) begin
            if (in_last) begin
                wcnt <= '0;
                if (wcnt >= LEN_W'(MAX_LEN)) begin
                    drop_count <= drop_count + 1'b1;
                end else begin
                    full       <= 1'b1;
                    frm_len    <= wcnt + 1'b1;
                    frm_status <= in_status;
                end
            end else if (wcnt != LEN_W'(MAX_LEN)) begin
                wcnt <= wcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rxagg_idle_timer.sv
// Idle window counter.
// Counts cycles while armed; expire is high once the count reaches limit.
// Disarming clears the count. A limit of zero expires on the first armed cycle.
module rxagg_idle_timer #(
    parameter int unsigned TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);
    logic [TMO_W-1:0] cnt;

    // Saturating count of armed cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = arm && (cnt >= limit);

endmodule

// File: rtl/rxagg_top.sv
// Receive frame aggregator top.
// Reads each stored frame out as a record (status, length low, length high,
// frame bytes). The record's final byte is held until the next frame's fit is
// known or the idle window expires, so out_last can be attached to it.
// Assumes XFER_BYTES >= MAX_PAYLOAD + FCS_BYTES + 3.
module rxagg_top #(
    parameter int unsigned MAX_PAYLOAD = 1514,
    parameter int unsigned FCS_BYTES   = 4,
    parameter int unsigned XFER_BYTES  = 3072,
    parameter int unsigned TMO_W       = 16,
    parameter int unsigned DROP_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic [7:0]        in_status,
    input  logic [TMO_W-1:0]  idle_limit,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last,
    output logic [DROP_W-1:0] drop_count
);
    import rxagg_pkg::*;

    localparam int unsigned MAX_LEN = MAX_PAYLOAD + FCS_BYTES;
    localparam int unsigned LEN_W   = $clog2(MAX_LEN + 2);
    localparam int unsigned USED_W  = $clog2(XFER_BYTES + 1);
    localparam int unsigned SUM_W   = $clog2(XFER_BYTES + MAX_LEN + HDR_BYTES + 1);

    emit_state_t       st;
    logic              pend_vld;
    logic [7:0]        pend_byte;
    logic [USED_W-1:0] used;
    logic [LEN_W-1:0]  rd_idx;

    logic              frm_ready;
    logic [LEN_W-1:0]  frm_len;
    logic [7:0]        frm_status;
    logic              frm_release;
    logic [7:0]        rd_data;
    logic              expire;
    logic              at_final;
    logic [SUM_W-1:0]  fill_sum;
    logic              fits;
    logic [15:0]       len_field;

    rxagg_capture #(
        .MAX_LEN (MAX_LEN),
        .LEN_W   (LEN_W),
        .DROP_W  (DROP_W)
    ) cap_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_data     (in_data),
        .in_last     (in_last),
        .in_status   (in_status),
        .frm_ready   (frm_ready),
        .frm_len     (frm_len),
        .frm_status  (frm_status),
        .frm_release (frm_release),
        .rd_addr     (rd_idx),
        .rd_data     (rd_data),
        .drop_count  (drop_count)
    );

    rxagg_idle_timer #(
        .TMO_W (TMO_W)
    ) tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (pend_vld && (st == ST_WAIT)),
        .limit  (idle_limit),
        .expire (expire)
    );

    // Transfer fill after appending the stored frame's record.
    assign fill_sum    = SUM_W'(used) + SUM_W'(frm_len) + SUM_W'(HDR_BYTES);
    assign fits        = fill_sum <= SUM_W'(XFER_BYTES);
    assign len_field   = 16'(frm_len);
    assign at_final    = (rd_idx == frm_len - 1'b1);
    assign frm_release = (st == ST_BODY) && at_final;

    // Output byte selection per emitter state.
    always_comb begin
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_last  = 1'b0;
        unique case (st)
            ST_JOIN:     begin out_valid = 1'b1; out_data = pend_byte; end
            ST_FLUSH:    begin out_valid = 1'b1; out_data = pend_byte; out_last = 1'b1; end
            ST_HDR_STAT: begin out_valid = 1'b1; out_data = frm_status; end
            ST_HDR_LO:   begin out_valid = 1'b1; out_data = len_field[7:0]; end
            ST_HDR_HI:   begin out_valid = 1'b1; out_data = len_field[15:8]; end
            ST_BODY:     begin out_valid = !at_final; out_data = rd_data; end
            default:     ;
        endcase
    end

    // Emitter sequencing, transfer fill tracking and final-byte hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_WAIT;
            pend_vld  <= 1'b0;
            pend_byte <= '0;
            used      <= '0;
            rd_idx    <= '0;
        end else begin
            unique case (st)
                ST_WAIT: begin
                    if (pend_vld && expire) begin
                        st <= ST_FLUSH;
                    end else if (frm_ready) begin
                        if (!pend_vld)  st <= ST_HDR_STAT;
                        else if (fits)  st <= ST_JOIN;
                        else            st <= ST_FLUSH;
                    end
                end
                ST_JOIN: begin
                    if (out_ready) begin
                        pend_vld <= 1'b0;
                        st       <= ST_HDR_STAT;
                    end
                end
                ST_FLUSH: begin
                    if (out_ready) begin
                        pend_vld <= 1'b0;
                        used     <= '0;
                        st       <= ST_WAIT;
                    end
                end
                ST_HDR_STAT: begin
                    if (out_ready) begin
                        used <= USED_W'(fill_sum);
                        st   <= ST_HDR_LO;
                    end
                end
                ST_HDR_LO: begin
                    if (out_ready) st <= ST_HDR_HI;
                end
                ST_HDR_HI: begin
                    if (out_ready) begin
                        rd_idx <= '0;
                        st     <= ST_BODY;
                    end
                end
                ST_BODY: begin
                    if (at_final) begin
                        pend_byte <= rd_data;
                        pend_vld  <= 1'b1;
                        st        <= ST_WAIT;
                    end else if (out_ready) begin
                        rd_idx <= rd_idx + 1'b1;
                    end
                end
                default: st <= ST_WAIT;
            endcase
        end
    end

endmodule

// File: rtl/rxagg_checker.sv
// Protocol checker for rxagg_top; attached by the bind at the end of this file.
// Tracks the byte count of the current transfer on its own.
module rxagg_checker #(
    parameter int unsigned XFER_BYTES = 3072,
    parameter int unsigned DROP_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_data,
    input logic              out_last,
    input logic [DROP_W-1:0] drop_count
);
    logic [31:0] xcnt;

    // Bytes handed over in the current transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xcnt <= '0;
        end else if (out_valid && out_ready) begin
            xcnt <= out_last ? '0 : xcnt + 1;
        end
    end

    // R1: the first cycle out of reset is idle and accepting.
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && in_ready && (drop_count == '0)));

    // R11: a stalled output byte holds.
    a_r11_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R8: the drop counter only steps by one.
    a_r8_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drop_count) |-> (drop_count == $past(drop_count) + 1'b1));

    // R6: no transfer grows beyond the buffer size.
    a_r6_xfer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |-> (xcnt < XFER_BYTES));

endmodule

bind rxagg_top rxagg_checker #(
    .XFER_BYTES (XFER_BYTES),
    .DROP_W     (DROP_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last),
    .drop_count (drop_count)
);

// File: tb/rxagg_top_tb_top.sv
// Scoreboard bench: send_frame models the expected record bytes and the
// transfer-end flags into a queue; a monitor pops and compares every output byte.
module rxagg_top_tb_top;
    localparam int XFER    = 3072;
    localparam int MAXLEN  = 1518;
    localparam int WD_CYC  = 150000;

    typedef struct {
        logic [7:0] d;
        logic       l;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic [7:0]  in_status = '0;
    logic [15:0] idle_limit = 16'd40;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic        out_last;
    logic [15:0] drop_count;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    int   used_m = 0;
    int   acc_m = 0;
    bit   pend_m = 0;
    int   drops_m = 0;
    int   rdy_mode = 0;
    int   pat = 0;
    bit   prev_stall = 0;
    logic [7:0] prev_d;
    logic       prev_l;

    always #5 clk = ~clk;

    rxagg_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_status  (in_status),
        .idle_limit (idle_limit),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_last   (out_last),
        .drop_count (drop_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // Downstream ready pattern: 0 always ready, 1 stalled, 2 intermittent.
    always begin
        @(posedge clk);
        #2;
        pat++;
        case (rdy_mode)
            1:       out_ready = 1'b0;
            2:       out_ready = ((pat % 3) != 0);
            default: out_ready = 1'b1;
        endcase
    end

    // Monitor: stall stability and scoreboard comparison.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                check(out_valid && out_data == prev_d && out_last == prev_l,
                      "R11", {out_valid, out_last, out_data}, {1'b1, prev_l, prev_d});
            end
            prev_stall = out_valid && !out_ready;
            prev_d = out_data;
            prev_l = out_last;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", out_data, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(out_data == e.d, e.tag, out_data, e.d);
                    check(out_last == e.l, e.tag, out_last, e.l);
                end
            end
        end
    end

    function automatic void close_tail(input string tag);
        exp_q[exp_q.size()-1].l = 1'b1;
        exp_q[exp_q.size()-1].tag = tag;
        used_m = 0;
        pend_m = 0;
        acc_m = 0;
    endfunction

    // Driver plus model; called at posedge+2, returns at posedge+2.
    task automatic send_frame(input int n, input logic [7:0] st, input logic [7:0] seed);
        bit drop;
        drop = (n > MAXLEN);
        if (pend_m) begin
            if (drop) begin
                acc_m += n;
                if (acc_m >= idle_limit) close_tail("R7");
            end else if (acc_m + n == idle_limit) begin
                close_tail("R9");
            end else if (acc_m + n > idle_limit) begin
                close_tail("R7");
            end else if (used_m + n + 3 > XFER) begin
                close_tail("R6");
            end else begin
                exp_q[exp_q.size()-1].tag = "R5";
            end
        end
        if (drop) begin
            drops_m++;
        end else begin
            exp_q.push_back('{st, 1'b0, "R4"});
            exp_q.push_back('{8'(n), 1'b0, (n == MAXLEN) ? "R8" : "R3"});
            exp_q.push_back('{8'(n >> 8), 1'b0, (n == MAXLEN) ? "R8" : "R3"});
            for (int i = 0; i < n; i++) exp_q.push_back('{8'(seed + i * 7), 1'b0, "R2"});
            used_m += n + 3;
            pend_m = 1;
            acc_m = 0;
        end
        for (int i = 0; i < n; i++) begin
            in_valid  = 1'b1;
            in_data   = 8'(seed + i * 7);
            in_last   = (i == n - 1);
            in_status = st;
            do @(negedge clk); while (!in_ready);
            @(posedge clk);
            #2;
        end
    endtask

    // Stop input and let the idle window close the open transfer.
    task automatic idle_flush();
        in_valid = 1'b0;
        in_last  = 1'b0;
        if (pend_m) close_tail("R7");
        wait (exp_q.size() == 0);
        repeat (3) @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", out_valid, 0);
        check(in_ready == 1'b1, "R1", in_ready, 1);
        check(drop_count == 16'd0, "R1", drop_count, 0);
        @(posedge clk);
        #2;

        // Small frames joined in one transfer under intermittent ready.
        rdy_mode = 2;
        idle_limit = 16'd40;
        send_frame(10, 8'h40, 8'h11);
        send_frame(12, 8'h41, 8'h22);
        send_frame(5, 8'h40, 8'h33);
        idle_flush();

        // Expiry and frame completion near and on the same cycle.
        rdy_mode = 0;
        idle_limit = 16'd20;
        send_frame(10, 8'h40, 8'h44);
        send_frame(20, 8'h40, 8'h55);
        send_frame(19, 8'h40, 8'h66);
        send_frame(21, 8'h40, 8'h77);
        idle_flush();

        // Buffer fill split and maximum-length frame.
        idle_limit = 16'd3000;
        send_frame(1000, 8'h40, 8'h01);
        send_frame(1000, 8'h40, 8'h02);
        send_frame(1000, 8'h40, 8'h03);
        send_frame(1000, 8'h40, 8'h04);
        send_frame(MAXLEN, 8'h40, 8'h05);
        idle_flush();

        // Oversized frame is discarded between two good ones.
        rdy_mode = 2;
        send_frame(30, 8'h40, 8'h88);
        send_frame(MAXLEN + 1, 8'h40, 8'h99);
        send_frame(25, 8'h40, 8'hAA);
        idle_flush();
        @(negedge clk);
        check(drop_count == 16'(drops_m), "R8", drop_count, drops_m);
        @(posedge clk);
        #2;

        // Backpressure: stored frame blocks input while output is stalled.
        rdy_mode = 1;
        idle_limit = 16'd40;
        send_frame(8, 8'h40, 8'hBB);
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check(in_ready == 1'b0, "R10", in_ready, 0);
        end
        @(posedge clk);
        #2;
        rdy_mode = 0;
        idle_flush();

        check(exp_q.size() == 0, "R2", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R2 actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule